// File: doc/BRIEF.md
# Three-Source Interrupt Arbiter with Return-Stack Guard

This block decides when a small microcontroller core takes an interrupt and where it goes. Three sources feed it: an external pin, a timer/event counter and an analog-to-digital converter. Each source delivers a single-cycle pulse that sets a sticky request flag. One control word holds the flags, one enable per source and a global enable. Software can read this word and can overwrite it, which lets it set or clear any flag.

When the global enable is set, some flag is pending with its enable set, and the core reports that its return stack has room, the block raises a take strobe. During the strobe it presents the source number and the fixed entry address. The core must push only its program counter and branch on that strobe. Processor status is never saved. On the same edge the block clears the global enable, which stops nesting, and clears the accepted flag.

A separate wake output pulses whenever an enabled request becomes pending, whatever the state of the global enable. This lets a halted core restart.

Top module: `irq_arbiter`

## Requirements
- R1: After asynchronous reset, ctrl_o reads 0, take_o is 0 and wake_o is 0.
- R2: Control word layout: bit 0 is the global enable. Bits 1, 2 and 3 enable the external, timer and converter sources. Bits 4, 5 and 6 are their request flags. Bit 7 always reads 0. A write with wr_en_i loads bits 0 to 6 from wr_data_i on the next edge.
- R3: A pulse on src_pulse_i[k] (0 external, 1 timer, 2 converter) sets flag k on the next edge, whatever the enables are. This set wins over a clearing write and over the clear caused by acceptance in the same cycle.
- R4: take_o is high in a cycle exactly when the global enable is 1, at least one flag is 1 with its own enable at 1, and stack_full_i is 0.
- R5: While stack_full_i is 1, take_o stays 0. A pending request is taken in the first cycle after stack_full_i returns to 0.
- R6: When several enabled requests are pending, the external source wins over the timer, and the timer wins over the converter.
- R7: While take_o is high, irq_id_o gives the winning source number. irq_vec_o gives its entry address: 0x004 for external, 0x008 for timer, 0x00C for converter.
- R8: On the edge that ends a take_o cycle, the global enable and the accepted flag become 0. All other flags and enables are kept.
- R9: A request that arrives while the global enable is 0 stays pending. It is taken as soon as software sets the global enable again.
- R10: wake_o is high for exactly one cycle when the set of pending enabled requests changes from empty to non-empty. The global enable has no effect on it.
- R11: A flag whose source enable is 0 never causes take_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| src_pulse_i | input | 3 | Request pulses: 0 external, 1 timer, 2 converter |
| wr_en_i | input | 1 | Control word write strobe |
| wr_data_i | input | 8 | Control word write data |
| ctrl_o | output | 8 | Control word read value |
| stack_full_i | input | 1 | Core return stack has no free entry |
| take_o | output | 1 | Interrupt accepted this cycle: push PC and branch |
| irq_id_o | output | 2 | Number of the winning source |
| irq_vec_o | output | 11 | Entry address during take_o, else 0 |
| wake_o | output | 1 | Wake-up pulse |

## Verification
The bench builds the block with its default parameters: three sources, an 8-bit control word, an 11-bit address, and entry addresses starting at 0x004 in steps of 4. With only three sources, every pairing of enable and flag patterns that matters for priority can be driven directly through control-word writes. These parameters also make it possible to watch the acceptance clear collide with both a write and a fresh pulse. With one global enable bit and one stack-full input, every path that blocks acceptance can be exercised from the ports within a few cycles.

// File: rtl/irq_pkg.sv
package irq_pkg;
  // control word field positions
  function automatic int gie_pos();
    return 0;
  endfunction
  function automatic int en_pos(int k);
    return 1 + k;
  endfunction
  function automatic int flag_pos(int n, int k);
    return 1 + n + k;
  endfunction
endpackage

// File: rtl/irq_ctrl_reg.sv
module irq_ctrl_reg #(
  parameter int N_SRC  = 3,
  parameter int DATA_W = 8,
  localparam int IW    = (N_SRC > 1) ? $clog2(N_SRC) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic [N_SRC-1:0]  set_i,
  input  logic              take_i,
  input  logic [IW-1:0]     take_idx_i,
  output logic              gie_o,
  output logic [N_SRC-1:0]  en_o,
  output logic [N_SRC-1:0]  req_o
);
  import irq_pkg::*;

  logic             gie_q, gie_n;
  logic [N_SRC-1:0] en_q, en_n, req_q, req_n;

  always_comb begin
    gie_n = gie_q;
    en_n  = en_q;
    req_n = req_q;
    if (wr_en_i) begin
      gie_n = wr_data_i[gie_pos()];
      for (int k = 0; k < N_SRC; k++) begin
        en_n[k]  = wr_data_i[en_pos(k)];
        req_n[k] = wr_data_i[flag_pos(N_SRC, k)];
      end
    end
    if (take_i) begin
      gie_n = 1'b0;
      for (int k = 0; k < N_SRC; k++)
        if (take_idx_i == IW'(k)) req_n[k] = 1'b0;
    end
    // fresh pulse beats any clear
    req_n = req_n | set_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      gie_q <= 1'b0;
      en_q  <= '0;
      req_q <= '0;
    end else begin
      gie_q <= gie_n;
      en_q  <= en_n;
      req_q <= req_n;
    end
  end

  assign gie_o = gie_q;
  assign en_o  = en_q;
  assign req_o = req_q;
endmodule

// File: rtl/irq_prio.sv
module irq_prio #(
  parameter int N_SRC = 3,
  localparam int IW   = (N_SRC > 1) ? $clog2(N_SRC) : 1
) (
  input  logic [N_SRC-1:0] cand_i,
  output logic             any_o,
  output logic [IW-1:0]    idx_o
);
  logic [N_SRC-1:0] grant;

  // lowest index wins
  for (genvar k = 0; k < N_SRC; k++) begin : g_grant
    if (k == 0) begin : g_first
      assign grant[k] = cand_i[k];
    end else begin : g_rest
      assign grant[k] = cand_i[k] & ~|cand_i[k-1:0];
    end
  end

  always_comb begin
    idx_o = '0;
    for (int k = 0; k < N_SRC; k++)
      if (grant[k]) idx_o = IW'(k);
  end

  assign any_o = |cand_i;
endmodule

// File: rtl/irq_wake.sv
module irq_wake (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pend_i,
  output logic wake_o
);
  logic prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= 1'b0;
    else         prev_q <= pend_i;
  end

  assign wake_o = pend_i & ~prev_q;
endmodule

// File: rtl/irq_arbiter.sv
module irq_arbiter #(
  parameter int N_SRC    = 3,
  parameter int DATA_W   = 8,
  parameter int VEC_W    = 11,
  parameter int VEC_BASE = 4,
  parameter int VEC_STEP = 4,
  localparam int IW      = (N_SRC > 1) ? $clog2(N_SRC) : 1,
  localparam int CTRL_W  = 1 + 2 * N_SRC
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [N_SRC-1:0]  src_pulse_i,
  input  logic              wr_en_i,
  input  logic [DATA_W-1:0] wr_data_i,
  output logic [DATA_W-1:0] ctrl_o,
  input  logic              stack_full_i,
  output logic              take_o,
  output logic [IW-1:0]     irq_id_o,
  output logic [VEC_W-1:0]  irq_vec_o,
  output logic              wake_o
);
  import irq_pkg::*;

  logic             gie;
  logic [N_SRC-1:0] en, req, cand;
  logic             any_pend;
  logic [IW-1:0]    win;

  irq_ctrl_reg #(.N_SRC(N_SRC), .DATA_W(DATA_W)) u_reg (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .wr_en_i    (wr_en_i),
    .wr_data_i  (wr_data_i),
    .set_i      (src_pulse_i),
    .take_i     (take_o),
    .take_idx_i (win),
    .gie_o      (gie),
    .en_o       (en),
    .req_o      (req)
  );

  assign cand = en & req;

  irq_prio #(.N_SRC(N_SRC)) u_prio (
    .cand_i (cand),
    .any_o  (any_pend),
    .idx_o  (win)
  );

  irq_wake u_wake (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .pend_i (any_pend),
    .wake_o (wake_o)
  );

  assign take_o    = gie & any_pend & ~stack_full_i;
  assign irq_id_o  = win;
  assign irq_vec_o = take_o ? VEC_W'(VEC_BASE + VEC_STEP * int'(win)) : '0;

  always_comb begin
    ctrl_o = '0;
    ctrl_o[gie_pos()] = gie;
    for (int k = 0; k < N_SRC; k++) begin
      ctrl_o[en_pos(k)]          = en[k];
      ctrl_o[flag_pos(N_SRC, k)] = req[k];
    end
  end

  if (DATA_W > CTRL_W) begin : g_pad
    logic unused_wr_hi;
    assign unused_wr_hi = ^wr_data_i[DATA_W-1:CTRL_W];
  end
endmodule

// File: rtl/irq_arbiter_chk.sv
module irq_arbiter_chk #(
  parameter int N_SRC    = 3,
  parameter int DATA_W   = 8,
  parameter int VEC_W    = 11,
  parameter int VEC_BASE = 4,
  localparam int IW      = (N_SRC > 1) ? $clog2(N_SRC) : 1
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [N_SRC-1:0]  src_pulse_i,
  input logic [DATA_W-1:0] ctrl_o,
  input logic              stack_full_i,
  input logic              take_o,
  input logic [IW-1:0]     irq_id_o,
  input logic [VEC_W-1:0]  irq_vec_o,
  input logic              wake_o
);
  p_full_blocks_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stack_full_i |-> !take_o);

  p_take_needs_gie_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    take_o |-> ctrl_o[0]);

  p_take_drops_gie_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    take_o |=> !ctrl_o[0]);

  p_take_drops_flag_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (take_o && !src_pulse_i[irq_id_o]) |=> !ctrl_o[1 + N_SRC + int'($past(irq_id_o))]);

  p_ext_vector_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (take_o && irq_id_o == '0) |-> irq_vec_o == VEC_W'(VEC_BASE));

  p_wake_single_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wake_o |=> !wake_o);

  for (genvar k = 0; k < N_SRC; k++) begin : g_latch
    p_pulse_sets_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      src_pulse_i[k] |=> ctrl_o[1 + N_SRC + k]);
  end
endmodule

bind irq_arbiter irq_arbiter_chk #(
  .N_SRC(N_SRC), .DATA_W(DATA_W), .VEC_W(VEC_W), .VEC_BASE(VEC_BASE)
) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .src_pulse_i  (src_pulse_i),
  .ctrl_o       (ctrl_o),
  .stack_full_i (stack_full_i),
  .take_o       (take_o),
  .irq_id_o     (irq_id_o),
  .irq_vec_o    (irq_vec_o),
  .wake_o       (wake_o)
);

// File: tb/sim_irq_arbiter.sv
`timescale 1ns/1ps
module sim_irq_arbiter;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [2:0]  src_pulse_i = '0;
  logic        wr_en_i = 1'b0;
  logic [7:0]  wr_data_i = '0;
  logic [7:0]  ctrl_o;
  logic        stack_full_i = 1'b0;
  logic        take_o;
  logic [1:0]  irq_id_o;
  logic [10:0] irq_vec_o;
  logic        wake_o;

  int errors = 0;
  int checks = 0;
  bit done = 0;

  always #2 clk_i = ~clk_i;

  irq_arbiter u0 (.*);

  // {wr data, stack full, take, id, vector}
  localparam int NV = 10;
  localparam logic [22:0] TBL [NV] = '{
    {8'h13, 1'b0, 1'b1, 2'd0, 11'h004},  // R4 R7 ext
    {8'h25, 1'b0, 1'b1, 2'd1, 11'h008},  // R7 timer
    {8'h49, 1'b0, 1'b1, 2'd2, 11'h00C},  // R7 converter
    {8'h7F, 1'b0, 1'b1, 2'd0, 11'h004},  // R6 all pending
    {8'h6D, 1'b0, 1'b1, 2'd1, 11'h008},  // R6 timer over converter
    {8'h7F, 1'b1, 1'b0, 2'd0, 11'h000},  // R5 stack full
    {8'h7E, 1'b0, 1'b0, 2'd0, 11'h000},  // R4 no global enable
    {8'h71, 1'b0, 1'b0, 2'd0, 11'h000},  // R11 no source enables
    {8'h43, 1'b0, 1'b0, 2'd0, 11'h000},  // R11 flag without enable
    {8'h4B, 1'b0, 1'b1, 2'd2, 11'h00C}   // R6 only converter enabled+pending
  };

  task automatic tick();
    @(posedge clk_i);
    @(negedge clk_i);
  endtask

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(logic [7:0] d);
    wr_en_i = 1'b1;
    wr_data_i = d;
    tick();
    wr_en_i = 1'b0;
  endtask

  initial begin
    #400000;
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    #5;
    @(negedge clk_i);
    // R1 reset state
    chk("R1 ctrl", ctrl_o, 0);
    chk("R1 take", take_o, 0);
    chk("R1 wake", wake_o, 0);
    rst_ni = 1'b1;
    tick();

    for (int i = 0; i < NV; i++) begin
      stack_full_i = TBL[i][14];
      wr(TBL[i][22:15]);
      chk("R4/R6 take", take_o, TBL[i][13]);
      if (TBL[i][13]) begin
        chk("R6/R7 id", irq_id_o, TBL[i][12:11]);
        chk("R7 vec", irq_vec_o, TBL[i][10:0]);
      end
      stack_full_i = 1'b0;
      wr(8'h00);
    end

    // R2 unused bit reads 0
    wr(8'hFF);
    stack_full_i = 1'b1;  // keep it from being taken
    chk("R2 readback", ctrl_o, 8'h7F);
    wr(8'h00);
    stack_full_i = 1'b0;

    // R8 acceptance clears gie and only the accepted flag
    wr(8'h37);
    chk("R8 take", take_o, 1);
    tick();
    chk("R8 ctrl after take", ctrl_o, 8'h26);
    chk("R8 no repeat", take_o, 0);

    // R9 pending timer taken once gie set again
    wr(8'h27);
    chk("R9 take", take_o, 1);
    chk("R9 id", irq_id_o, 1);
    chk("R9 vec", irq_vec_o, 11'h008);
    wr(8'h00);

    // R3 pulse with everything disabled
    src_pulse_i = 3'b100;
    tick();
    src_pulse_i = '0;
    chk("R3 latch", ctrl_o, 8'h40);
    // R3 pulse beats a clearing write
    wr_en_i = 1'b1;
    wr_data_i = 8'h00;
    src_pulse_i = 3'b010;
    tick();
    wr_en_i = 1'b0;
    src_pulse_i = '0;
    chk("R3 beats write", ctrl_o, 8'h20);
    wr(8'h00);
    // R3 pulse beats acceptance clear
    wr(8'h13);
    chk("R3 take", take_o, 1);
    src_pulse_i = 3'b001;
    tick();
    src_pulse_i = '0;
    chk("R3 beats take", ctrl_o, 8'h12);
    wr(8'h00);

    // R5 stack full holds off, then release
    stack_full_i = 1'b1;
    wr(8'h13);
    tick();
    tick();
    chk("R5 held", take_o, 0);
    chk("R5 flag kept", ctrl_o, 8'h13);
    stack_full_i = 1'b0;
    #0.5;
    chk("R5 resumes", take_o, 1);
    wr(8'h00);

    // R10 wake independent of gie
    wr(8'h02);
    chk("R10 idle", wake_o, 0);
    src_pulse_i = 3'b001;
    tick();
    src_pulse_i = '0;
    chk("R10 pulse", wake_o, 1);
    chk("R10 no take", take_o, 0);
    tick();
    chk("R10 one cycle", wake_o, 0);
    // R10 disabled source gives no wake
    wr(8'h00);
    src_pulse_i = 3'b100;
    tick();
    src_pulse_i = '0;
    chk("R10 disabled", wake_o, 0);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule